// File: doc/BRIEF.md
# Rotate-Then-Logical Selected-Bits Unit

This is a datapath unit that serves three related operations. It rotates a second register operand left by an immediate amount. It then merges a contiguous range of bit positions from that rotated value into a first register operand, using AND, OR or XOR. Bits outside the range come from the first operand unchanged. The range is given as a start and an end position. Positions are counted from the most significant bit. When the start lies after the end, the range wraps around the top of the word.

The unit also produces a condition code that says whether any bit of the result inside the range is set. A flag bit in the start immediate selects a test-only form. That form updates the condition code but does not write the result back. An unrecognised secondary opcode raises an error flag and produces no result. All outputs are registered and appear one cycle after the input strobe.

Top module: `rsb_unit`

## Requirements
- R1: `sub_op` 0x54 selects AND, 0x56 selects OR and 0x57 selects XOR. For any other value the unit produces no result: `out_err`=1, `out_we`=0, `out_cc`=0 and `out_data` equals `opnd_a`.
- R2: Only the low 6 bits of `imm_start`, `imm_end` and `imm_rot` act as positions or amounts. Bits 7:6 of `imm_end` and `imm_rot`, and bit 6 of `imm_start`, have no effect on any output.
- R3: When `imm_start` bit 7 is 1 (test-only form), `out_we`=0 and `out_data` equals `opnd_a`. `out_cc` is still computed as in R9.
- R4: Position p maps to data bit 63-p. When start ≤ end, the mask covers positions start through end inclusive.
- R5: When start > end, the mask covers positions start through 63 together with positions 0 through end.
- R6: `opnd_b` is rotated left by the 6-bit rotate amount before it is combined. An amount of 0 leaves it unchanged.
- R7: For AND, rotated bits outside the mask are treated as 1. The result is `opnd_a & (rot | ~mask)`.
- R8: For OR and XOR, rotated bits outside the mask are treated as 0. The result is `opnd_a | (rot & mask)` or `opnd_a ^ (rot & mask)`. Bits outside the mask always equal `opnd_a`.
- R9: For a legal opcode, `out_cc` is 0 when (result & mask) is zero and 1 otherwise. Bit 1 of `out_cc` is never set.
- R10: Outputs update on the clock edge that samples `in_valid`=1 and `out_valid` rises with them. A cycle with `in_valid`=0 gives `out_valid`=`out_we`=`out_err`=0 on the next cycle. Reset clears `out_valid`, `out_we` and `out_err`.
- R11: When start = end, exactly one bit position is selected.
- R12: In the normal form with a legal opcode, `out_we`=1 and `out_data` carries the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| sub_op | input | 8 | Secondary opcode selecting the logical function |
| imm_start | input | 8 | Start position (bits 5:0), test-only flag (bit 7) |
| imm_end | input | 8 | End position (bits 5:0) |
| imm_rot | input | 8 | Left-rotate amount (bits 5:0) |
| opnd_a | input | DATA_W (64) | First operand, also the old destination value |
| opnd_b | input | DATA_W (64) | Second operand, the one that is rotated |
| out_valid | output | 1 | Registered result valid |
| out_we | output | 1 | Result write enable |
| out_err | output | 1 | Illegal secondary opcode |
| out_cc | output | 2 | Condition code (0 or 1) |
| out_data | output | DATA_W (64) | Result, or `opnd_a` when nothing is written |

## Verification
The bench builds the unit with its default width of 64 bits, so positions are 6 bits wide. Under that setting, every case described in the requirements can be reached: masks that wrap across the boundary from position 63 to position 0, the full-width mask (start 0, end 63), single-bit masks at both ends of the word, and rotate amounts from 0 up to 63. Immediates with their unused upper bits set are also applied, to show that those bits are ignored. Expected values come from a shift-based reference model. This model computes the mask differently from the per-position comparison used in the RTL.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam logic [7:0] OPC_AND = 8'h54;
  localparam logic [7:0] OPC_OR  = 8'h56;
  localparam logic [7:0] OPC_XOR = 8'h57;
  localparam int unsigned TEST_FLAG_BIT = 7;

  typedef enum logic [1:0] {
    LOP_AND  = 2'd0,
    LOP_OR   = 2'd1,
    LOP_XOR  = 2'd2,
    LOP_NONE = 2'd3
  } lop_e;

  function automatic lop_e decode_op(input logic [7:0] op);
    case (op)
      OPC_AND: decode_op = LOP_AND;
      OPC_OR:  decode_op = LOP_OR;
      OPC_XOR: decode_op = LOP_XOR;
      default: decode_op = LOP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rsb_mask_gen.sv
module rsb_mask_gen #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]  pos_first,
  input  logic [POS_W-1:0]  pos_last,
  output logic [DATA_W-1:0] sel_mask
);
  logic no_wrap;
  assign no_wrap = (pos_first <= pos_last);

  // Position numbering runs from the MSB: position p is data bit DATA_W-1-p.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [POS_W-1:0] POS = POS_W'(DATA_W - 1 - i);
    logic at_or_after_first, at_or_before_last;
    assign at_or_after_first = (POS >= pos_first);
    assign at_or_before_last = (POS <= pos_last);
    assign sel_mask[i] = no_wrap ? (at_or_after_first && at_or_before_last)
                                 : (at_or_after_first || at_or_before_last);
  end

  // R11: a range that starts and ends at the same position is a single bit
  always_comb begin
    if (pos_first == pos_last) begin
      a_r11_single_bit: assert ($countones(sel_mask) == 1)
        else $error("R11 mask is not one bit wide");
    end
  end
endmodule

// File: rtl/rsb_rotl.sv
module rsb_rotl #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [POS_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [0:POS_W];
  assign stage[0] = din;

  for (genvar k = 0; k < POS_W; k++) begin : g_stage
    localparam int unsigned SH = 2 ** k;
    assign stage[k+1] = amt[k]
      ? {stage[k][DATA_W-1-SH:0], stage[k][DATA_W-1:DATA_W-SH]}
      : stage[k];
  end

  assign dout = stage[POS_W];

  // R6: a zero amount passes the operand through
  always_comb begin
    if (amt == '0) begin
      a_r6_zero_rotate: assert (dout == din)
        else $error("R6 zero rotate changed data");
    end
  end
endmodule

// File: rtl/rsb_combine.sv
module rsb_combine
  import rsb_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  lop_e              op,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] rot_in,
  input  logic [DATA_W-1:0] sel_mask,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] and_src, merge_src;
  assign and_src   = rot_in | ~sel_mask;
  assign merge_src = rot_in & sel_mask;

  always_comb begin
    case (op)
      LOP_AND: res = dst_in & and_src;
      LOP_OR:  res = dst_in | merge_src;
      LOP_XOR: res = dst_in ^ merge_src;
      default: res = dst_in;
    endcase
  end

  // R7/R8: bits outside the mask are always the first operand's bits
  always_comb begin
    if (op != LOP_NONE) begin
      a_r8_outside_unchanged: assert (((res ^ dst_in) & ~sel_mask) == '0)
        else $error("R8 unselected bits altered");
    end
  end
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        sub_op,
  input  logic [7:0]        imm_start,
  input  logic [7:0]        imm_end,
  input  logic [7:0]        imm_rot,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic              out_we,
  output logic              out_err,
  output logic [1:0]        out_cc,
  output logic [DATA_W-1:0] out_data
);
  lop_e              op;
  logic              legal, test_only;
  logic [DATA_W-1:0] mask, rotated, comb_res;
  logic              sel_nonzero;
  logic              unused_imm_bits;

  assign op        = decode_op(sub_op);
  assign legal     = (op != LOP_NONE);
  assign test_only = imm_start[TEST_FLAG_BIT];
  assign unused_imm_bits = ^{imm_start[6:POS_W], imm_end[7:POS_W], imm_rot[7:POS_W]};

  rsb_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .pos_first (imm_start[POS_W-1:0]),
    .pos_last  (imm_end[POS_W-1:0]),
    .sel_mask  (mask)
  );

  rsb_rotl #(.DATA_W(DATA_W)) u_rot (
    .din  (opnd_b),
    .amt  (imm_rot[POS_W-1:0]),
    .dout (rotated)
  );

  rsb_combine #(.DATA_W(DATA_W)) u_comb (
    .op       (op),
    .dst_in   (opnd_a),
    .rot_in   (rotated),
    .sel_mask (mask),
    .res      (comb_res)
  );

  assign sel_nonzero = |(comb_res & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_err   <= 1'b0;
      out_cc    <= 2'd0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= in_valid && legal && !test_only;
      out_err   <= in_valid && !legal;
      if (in_valid) begin
        out_data <= (legal && !test_only) ? comb_res : opnd_a;
        out_cc   <= legal ? {1'b0, sel_nonzero} : 2'd0;
      end
    end
  end

  // R10: one-cycle latency for the valid strobe
  a_r10_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_we && !out_err));
  // R1: an unknown opcode flags an error and never writes
  a_r1_illegal_op: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sub_op != OPC_AND && sub_op != OPC_OR && sub_op != OPC_XOR)
    |=> (out_err && !out_we && out_cc == 2'd0));
  // R3: the test-only form returns the old destination and suppresses writeback
  a_r3_test_only: assert property (@(posedge clk) disable iff (rst)
    (in_valid && imm_start[7]) |=> (!out_we && out_data == $past(opnd_a)));
  // R9: the condition code only takes the values 0 and 1
  a_r9_cc_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_cc[1]);
  // R12: a write never comes with an error
  a_r12_we_excl_err: assert property (@(posedge clk) disable iff (rst)
    out_we |-> (out_valid && !out_err));
endmodule

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb;
  localparam int NV = 16;
  localparam logic [7:0] OA = 8'h54, OO = 8'h56, OX = 8'h57;

  // stimulus table: op, start, end, rot, a, b
  localparam logic [7:0] T_OP [NV] = '{OA, OO, OX, OA, OO, OX, OA, OO,
                                       OX, OA, OO, OX, OA, OO, OX, OX};
  localparam logic [7:0] T_S  [NV] = '{8'd0, 8'd0, 8'd10, 8'd60, 8'd63, 8'd32, 8'd5, 8'd40,
                                       8'd1, 8'd62, 8'd0, 8'd63, 8'h40, 8'd17, 8'd50, 8'd7};
  localparam logic [7:0] T_E  [NV] = '{8'd63, 8'd63, 8'd20, 8'd3, 8'd63, 8'd31, 8'd5, 8'd8,
                                       8'd62, 8'd1, 8'd0, 8'd0, 8'hC5, 8'h91, 8'd2, 8'd7};
  localparam logic [7:0] T_R  [NV] = '{8'd0, 8'd13, 8'd1, 8'd63, 8'd32, 8'd7, 8'd0, 8'd55,
                                       8'd31, 8'd2, 8'd63, 8'd1, 8'h47, 8'hFF, 8'd9, 8'd60};
  localparam logic [63:0] T_A [NV] = '{
    64'hFFFF_0000_FFFF_0000, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0_F0F0_0F0F_0F0F,
    64'h0, 64'hA5A5_A5A5_5A5A_5A5A, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1111_2222_3333_4444,
    64'hDEAD_BEEF_CAFE_F00D, 64'h8000_0000_0000_0001, 64'h0, 64'h7FFF_FFFF_FFFF_FFFE,
    64'h0F0F_0F0F_0F0F_0F0F, 64'h0, 64'hCCCC_CCCC_CCCC_CCCC, 64'h0000_0000_0100_0000};
  localparam logic [63:0] T_B [NV] = '{
    64'h1234_5678_9ABC_DEF0, 64'h8000_0000_0000_0001, 64'h0000_0000_00FF_F000, 64'h0,
    64'h0000_0000_0000_0001, 64'hFFFF_FFFF_0000_0000, 64'h0, 64'hFEDC_BA98_7654_3210,
    64'h5555_5555_5555_5555, 64'h0, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000,
    64'h3C3C_3C3C_3C3C_3C3C, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0010};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  sub_op = 8'h0, imm_start = 8'h0, imm_end = 8'h0, imm_rot = 8'h0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic        out_valid, out_we, out_err;
  logic [1:0]  out_cc;
  logic [63:0] out_data;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rsb_unit #(.DATA_W(64)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sub_op(sub_op),
    .imm_start(imm_start), .imm_end(imm_end), .imm_rot(imm_rot),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .out_valid(out_valid), .out_we(out_we), .out_err(out_err),
    .out_cc(out_cc), .out_data(out_data)
  );

  function automatic logic [63:0] ref_mask(input int s, input int e);
    logic [63:0] ones = ~64'd0;
    logic [63:0] m = ones >> s;
    if (s <= e) m = m ^ ((ones >> e) >> 1);
    else        m = m | ~((ones >> e) >> 1);
    return m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] s, input logic [7:0] e,
                       input logic [7:0] r, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; sub_op = op; imm_start = s; imm_end = e; imm_rot = r;
    opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // compare all outputs with the reference model
  task automatic run_ref(input string req, input logic [7:0] op, input logic [7:0] s,
                         input logic [7:0] e, input logic [7:0] r,
                         input logic [63:0] a, input logic [63:0] b);
    logic [63:0] m, rb, res, exp_data;
    logic legal, tonly, exp_we, exp_err;
    logic [1:0] exp_cc;
    int rs;
    drive(op, s, e, r, a, b);
    m = ref_mask(int'(s[5:0]), int'(e[5:0]));
    rs = int'(r[5:0]);
    rb = (rs == 0) ? b : ((b << rs) | (b >> (64 - rs)));
    legal = (op == OA) || (op == OO) || (op == OX);
    tonly = s[7];
    case (op)
      OA:      res = a & (rb | ~m);
      OO:      res = a | (rb & m);
      OX:      res = a ^ (rb & m);
      default: res = a;
    endcase
    exp_we   = legal && !tonly;
    exp_err  = !legal;
    exp_data = exp_we ? res : a;
    exp_cc   = legal ? {1'b0, |(res & m)} : 2'd0;
    check({req, " R10 valid"}, 64'(out_valid), 64'd1);
    check({req, " R12/R3 we"}, 64'(out_we), 64'(exp_we));
    check({req, " R1 err"}, 64'(out_err), 64'(exp_err));
    check({req, " R9 cc"}, 64'(out_cc), 64'(exp_cc));
    check({req, " data"}, out_data, exp_data);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset valid", 64'(out_valid), 64'd0);
    check("R10 reset we", 64'(out_we), 64'd0);
    check("R10 reset err", 64'(out_err), 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      run_ref("R4/R5/R6/R7/R8 table", T_OP[i], T_S[i], T_E[i], T_R[i], T_A[i], T_B[i]);

    // R4: full mask with AND of zero clears everything
    drive(OA, 8'd0, 8'd63, 8'd0, ~64'd0, 64'd0);
    check("R4 full-mask and", out_data, 64'd0);
    check("R9 cc zero", 64'(out_cc), 64'd0);
    // R6/R11: bit 0 rotated by 63 lands at position 0 (data bit 63)
    drive(OO, 8'd0, 8'd0, 8'd63, 64'd0, 64'd1);
    check("R6 R11 rotate single bit", out_data, 64'h8000_0000_0000_0000);
    check("R9 cc one", 64'(out_cc), 64'd1);
    // R11: single bit at position 63
    drive(OX, 8'd63, 8'd63, 8'd0, 64'd0, ~64'd0);
    check("R11 single bit pos63", out_data, 64'd1);
    // R5: wrap start 62 end 1 selects data bits 1:0 and 63:62
    drive(OO, 8'd62, 8'd1, 8'd0, 64'd0, ~64'd0);
    check("R5 wrap mask", out_data, 64'hC000_0000_0000_0003);
    // R2: upper immediate bits ignored
    drive(OO, 8'h40, 8'hC0, 8'hC1, 64'd0, 64'h4000_0000_0000_0000);
    check("R2 upper bits ignored", out_data, 64'h8000_0000_0000_0000);
    // R3: test-only keeps destination, cc still reported
    drive(OO, 8'h80, 8'd63, 8'd0, 64'h1234, ~64'd0);
    check("R3 test-only data", out_data, 64'h1234);
    check("R3 test-only we", 64'(out_we), 64'd0);
    check("R3 test-only cc", 64'(out_cc), 64'd1);
    // R1: opcode 0x55 is not legal
    drive(8'h55, 8'd0, 8'd63, 8'd0, 64'hABCD, ~64'd0);
    check("R1 illegal err", 64'(out_err), 64'd1);
    check("R1 illegal data", out_data, 64'hABCD);
    check("R1 illegal we", 64'(out_we), 64'd0);
    run_ref("R1 illegal ref", 8'h00, 8'h85, 8'd3, 8'd4, 64'h77, 64'h99);
    run_ref("R3 test-only ref", OX, 8'hBC, 8'd2, 8'd17, 64'hFACE, 64'hFFFF_0000_0000_FFFF);
    // R10: idle cycle clears strobes
    @(negedge clk);
    check("R10 idle valid", 64'(out_valid), 64'd0);
    check("R10 idle we", 64'(out_we), 64'd0);
    check("R10 idle err", 64'(out_err), 64'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule